// File: doc/BRIEF.md
# Streaming Three-Tap Horizontal Blur

The block smooths a raster image along each row by replacing every pixel with the mean of itself and the two pixels that came before it in the stream. Pixels arrive as a valid-qualified data word. Each averaged pixel leaves as a registered valid-qualified word exactly one clock later. A frame counter counts accepted beats and raises a last flag alongside the final averaged pixel of each frame.

The `LANES` parameter, 1 or 2, sets how many pixels the block takes per clock. With two lanes the block builds two averaging datapaths and feeds the two-pixel history across beat boundaries. As a result, the two-lane block emits exactly the pixel sequence that the one-lane block would. With the default 2560x1440 frame, a full frame takes 3,686,400 beats with one lane and 1,843,200 beats with two. At 250 MHz that is roughly 15 ms and 7.5 ms per frame.

The history is cleared after the last pixel of every frame. The first two outputs of a frame therefore treat the missing earlier pixels as zero. The block has no backpressure.

Top module: `blur_stream`

## Requirements
- R1: With LANES=1, each accepted pixel x[n] yields one output equal to floor((x[n] + x[n-1] + x[n-2]) / 3).
- R2: With LANES=2, bits [PIX_W-1:0] carry the earlier pixel (lane 0) and bits [2*PIX_W-1:PIX_W] the later one (lane 1), on both input and output. The output pixel stream equals the one-lane stream for the same input pixels.
- R3: In two-lane mode, lane 0 averages itself with the two pixels of the previous beat. Lane 1 averages itself, lane 0 of the same beat, and lane 1 of the previous beat.
- R4: The three-pixel sum is formed PIX_W+2 bits wide, so three maximum-value pixels average to the maximum value with no wrap.
- R5: out_valid_o is high in exactly the cycles that follow a cycle with in_valid_i high.
- R6: A cycle with in_valid_i low changes neither the pixel history nor the frame beat count.
- R7: out_last_o is high with the output of beat number FRAME_W*FRAME_H/LANES of each frame, and low otherwise.
- R8: After the last beat of a frame the history is zero, so the first outputs of the next frame treat missing pixels as 0.
- R9: Reset drives out_valid_o, out_last_o and out_data_o to 0, clears the history and restarts the frame count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat valid |
| in_data_i | input | LANES*PIX_W | Input pixels, lane 0 in the low bits |
| out_valid_o | output | 1 | Output beat valid |
| out_data_o | output | LANES*PIX_W | Averaged pixels, lane 0 in the low bits |
| out_last_o | output | 1 | Final output beat of the frame |

## Verification
The bench drives a one-lane and a two-lane instance with the same pixel stream and checks both against a single scoreboard model. A history that does not cross beat boundaries would therefore show up as a two-lane mismatch on every lane-0 output. Frames of all-maximum pixels expose a sum that is too narrow, which would wrap to small averages. Back-to-back frames expose a history left uncleared, which would leak the previous frame's tail into the first two outputs. Idle gaps and a mid-frame reset expose a history or counter that moves without valid input, which would shift the averages or misplace the last flag.

// File: rtl/blur_pkg.sv
package blur_pkg;
  function automatic int unsigned beats_per_frame(int unsigned w, int unsigned h,
                                                  int unsigned lanes);
    return (w * h) / lanes;
  endfunction
endpackage

// File: rtl/blur_avg3.sv
module blur_avg3 #(
  parameter int unsigned PIX_W = 8
) (
  input  logic [PIX_W-1:0] a_i,
  input  logic [PIX_W-1:0] b_i,
  input  logic [PIX_W-1:0] c_i,
  output logic [PIX_W-1:0] avg_o
);
  localparam int unsigned SUM_W = PIX_W + 2;

  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] quo;

  always_comb begin
    sum   = SUM_W'(a_i) + SUM_W'(b_i) + SUM_W'(c_i);
    quo   = sum / SUM_W'(3);
    avg_o = quo[PIX_W-1:0];
  end
endmodule

// File: rtl/blur_window.sv
module blur_window #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned LANES = 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         valid_i,
  input  logic                         clear_i,
  input  logic [LANES*PIX_W-1:0]       lanes_i,
  output logic [(LANES+2)*PIX_W-1:0]   win_o
);
  logic [PIX_W-1:0] h_old_q, h_new_q;
  logic [PIX_W-1:0] win [LANES+2];

  assign win[0] = h_old_q;
  assign win[1] = h_new_q;
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign win[k+2] = lanes_i[k*PIX_W +: PIX_W];
  end
  for (genvar k = 0; k < LANES + 2; k++) begin : g_flat
    assign win_o[k*PIX_W +: PIX_W] = win[k];
  end

  // history spans beats: the two newest pixels of this beat
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_old_q <= '0;
      h_new_q <= '0;
    end else if (valid_i) begin
      if (clear_i) begin
        h_old_q <= '0;
        h_new_q <= '0;
      end else begin
        h_old_q <= win[LANES];
        h_new_q <= win[LANES+1];
      end
    end
  end

  a_r8_hist_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && clear_i) |=> (h_old_q == '0 && h_new_q == '0));

  a_r6_hist_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(h_old_q) && $stable(h_new_q)));
endmodule

// File: rtl/blur_frame_ctr.sv
module blur_frame_ctr #(
  parameter int unsigned BEATS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic last_o
);
  localparam int unsigned CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BEATS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign last_o = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (valid_i) cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end

  a_r7_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);

  a_r6_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cnt_q));
endmodule

// File: rtl/blur_stream.sv
module blur_stream
  import blur_pkg::*;
#(
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned LANES   = 1,
  parameter int unsigned FRAME_W = 2560,
  parameter int unsigned FRAME_H = 1440
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  input  logic [LANES*PIX_W-1:0] in_data_i,
  output logic                   out_valid_o,
  output logic [LANES*PIX_W-1:0] out_data_o,
  output logic                   out_last_o
);
  localparam int unsigned BEATS = beats_per_frame(FRAME_W, FRAME_H, LANES);

  if (!(LANES == 1 || LANES == 2)) begin : g_bad_lanes
    $error("LANES must be 1 or 2");
  end

  logic                         frame_last;
  logic [(LANES+2)*PIX_W-1:0]   win;
  logic [LANES*PIX_W-1:0]       avg;

  blur_frame_ctr #(.BEATS(BEATS)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .last_o  (frame_last)
  );

  blur_window #(.PIX_W(PIX_W), .LANES(LANES)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .clear_i (frame_last),
    .lanes_i (in_data_i),
    .win_o   (win)
  );

  // lane k window: positions k, k+1, k+2 of {h_old, h_new, lanes}
  for (genvar k = 0; k < LANES; k++) begin : g_avg
    blur_avg3 #(.PIX_W(PIX_W)) u_avg (
      .a_i   (win[k*PIX_W +: PIX_W]),
      .b_i   (win[(k+1)*PIX_W +: PIX_W]),
      .c_i   (win[(k+2)*PIX_W +: PIX_W]),
      .avg_o (avg[k*PIX_W +: PIX_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      out_last_o  <= in_valid_i && frame_last;
      if (in_valid_i) out_data_o <= avg;
    end
  end

  a_r5_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  a_r5_idle_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  a_r7_last_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);

  a_r6_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |=> (out_valid_o || $stable(out_data_o)));
endmodule

// File: tb/blur_stream_test.sv
module blur_stream_test;
  localparam int PW = 8;
  localparam int FW = 6;
  localparam int FH = 2;
  localparam int NPIX = FW * FH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        v1, v2;
  logic [7:0]  d1;
  logic [15:0] d2;
  logic        o1v, o1l, o2v, o2l;
  logic [7:0]  o1d;
  logic [15:0] o2d;

  blur_stream #(.PIX_W(PW), .LANES(2), .FRAME_W(FW), .FRAME_H(FH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(v2), .in_data_i(d2),
    .out_valid_o(o2v), .out_data_o(o2d), .out_last_o(o2l));

  blur_stream #(.PIX_W(PW), .LANES(1), .FRAME_W(FW), .FRAME_H(FH)) uut_one (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(v1), .in_data_i(d1),
    .out_valid_o(o1v), .out_data_o(o1d), .out_last_o(o1l));

  typedef struct {
    logic [15:0] data;
    logic        last;
    string       tag;
  } exp_t;

  exp_t q1[$];
  exp_t q2[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] pix [0:63];

  // bench model state
  logic [7:0] s_a, s_b, t_a, t_b;
  int s_cnt, t_cnt, s_frm, t_frm;

  function automatic logic [7:0] avg3(logic [7:0] a, logic [7:0] b, logic [7:0] c);
    logic [9:0] s;
    s = {2'b0, a} + {2'b0, b} + {2'b0, c};
    return 8'(s / 3);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    s_a = 0; s_b = 0; t_a = 0; t_b = 0;
    s_cnt = 0; t_cnt = 0; s_frm = 0; t_frm = 0;
  endtask

  task automatic drive1(int first, int n, bit gaps, string base);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      logic [7:0] p;
      p = pix[first + i];
      e.data = {8'h0, avg3(s_a, s_b, p)};
      e.last = (s_cnt == NPIX - 1);
      e.tag  = (s_frm > 0 && s_cnt < 2) ? "R8" : base;
      q1.push_back(e);
      if (e.last) begin
        s_a = 0; s_b = 0; s_cnt = 0; s_frm++;
      end else begin
        s_a = s_b; s_b = p; s_cnt++;
      end
      @(negedge clk); v1 = 1'b1; d1 = p;
      if (gaps && (i % 4 == 3)) begin
        @(negedge clk); v1 = 1'b0; d1 = 8'hxx ^ 8'h00; d1 = 8'h5a;
      end
    end
    @(negedge clk); v1 = 1'b0;
  endtask

  task automatic drive2(int first, int nb, bit gaps, string base);
    for (int i = 0; i < nb; i++) begin
      exp_t e;
      logic [7:0] p0, p1, e0, e1;
      p0 = pix[first + 2*i];
      p1 = pix[first + 2*i + 1];
      e0 = avg3(t_a, t_b, p0);  // R3 lane 0 uses previous beat
      e1 = avg3(t_b, p0, p1);   // R3 lane 1 uses lane 0 and previous lane 1
      e.data = {e1, e0};
      e.last = (t_cnt == NPIX/2 - 1);
      e.tag  = (t_frm > 0 && t_cnt == 0) ? "R8" : base;
      q2.push_back(e);
      if (e.last) begin
        t_a = 0; t_b = 0; t_cnt = 0; t_frm++;
      end else begin
        t_a = p0; t_b = p1; t_cnt++;
      end
      @(negedge clk); v2 = 1'b1; d2 = {p1, p0};
      if (gaps && (i % 2 == 1)) begin
        @(negedge clk); v2 = 1'b0; d2 = 16'ha5a5;
      end
    end
    @(negedge clk); v2 = 1'b0;
  endtask

  // scoreboard monitors, sampled 2 ns after the rising edge
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rst_n && !done) begin
        check("R5", "one-lane out_valid", int'(o1v), int'(v1));
        check("R5", "two-lane out_valid", int'(o2v), int'(v2));
        if (o1v) begin
          if (q1.size() == 0) check("R1", "one-lane unexpected output", 1, 0);
          else begin
            exp_t e;
            e = q1.pop_front();
            check(e.tag, "one-lane data (R1)", int'(o1d), int'(e.data[7:0]));
            check("R7", "one-lane last", int'(o1l), int'(e.last));
          end
        end else check("R7", "one-lane last while idle", int'(o1l), 0);
        if (o2v) begin
          if (q2.size() == 0) check("R2", "two-lane unexpected output", 1, 0);
          else begin
            exp_t e;
            e = q2.pop_front();
            check(e.tag, "two-lane data (R2 R3)", int'(o2d), int'(e.data));
            check("R7", "two-lane last", int'(o2l), int'(e.last));
          end
        end else check("R7", "two-lane last while idle", int'(o2l), 0);
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      if (i < 12)      pix[i] = 8'(i * 20 + 3);
      else if (i < 24) pix[i] = 8'hff;
      else if (i < 36) pix[i] = 8'((i * 37 + 11) & 255);
      else             pix[i] = 8'((i * 53 + 7) & 255);
    end
    v1 = 0; v2 = 0; d1 = 0; d2 = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "reset out_valid", int'(o1v | o2v), 0);
    check("R9", "reset out_last", int'(o1l | o2l), 0);
    check("R9", "reset out_data", int'(o1d) + int'(o2d), 0);
    rst_n = 1'b1;
    @(negedge clk);

    fork drive1(0, 12, 1'b0, "R1"); drive2(0, 6, 1'b0, "R2"); join
    fork drive1(12, 12, 1'b0, "R4"); drive2(12, 6, 1'b0, "R4"); join
    fork drive1(24, 12, 1'b1, "R6"); drive2(24, 6, 1'b1, "R6"); join
    // partial frame, then reset mid-frame
    fork drive1(36, 4, 1'b0, "R1"); drive2(36, 2, 1'b0, "R3"); join
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    check("R9", "mid-frame reset out_valid", int'(o1v | o2v), 0);
    check("R9", "mid-frame reset out_data", int'(o1d) + int'(o2d), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork drive1(40, 12, 1'b0, "R9"); drive2(40, 6, 1'b0, "R9"); join
    repeat (4) @(negedge clk);

    check("R1", "one-lane outputs left pending", q1.size(), 0);
    check("R2", "two-lane outputs left pending", q2.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule